// File: doc/BRIEF.md
# Vectored Fixed-Priority Interrupt Controller

This block gathers interrupt events from on-chip peripherals (four timers, a serial port, an analog converter), from five external pins and from a software break instruction. Each event is latched into a pending bit. The block picks the most urgent pending source that is allowed through and raises a request to the CPU together with the 16-bit address of that source's two-byte vector. The CPU acknowledges the request. The controller then clears that source's pending bit and sets the global mask flag, so that the handler starts with interrupts off.

Software reaches four small registers through a 2-bit address port. It can clear pending bits, set the per-source enables, choose the active edge of the external pins and change the global mask flag. A parameter selects one of two variants. In one, the serial port has a single source. In the other, receive and transmit are separate sources. Both variants use the same vector layout.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, slot 0 (the reset slot) is pending, the global mask flag reads 1, and all enables and polarity bits read 0. On the first clock edge after reset is released, `irq_req` rises with vector 16'hFFFE, even though the mask flag is 1.
- R2: Slots are numbered 0..11: 0 reset, 1 ext0, 2 ext1 or key wake-up, 3 counter pins, 4..7 timers 0..3, 8 serial receive, 9 serial transmit (or the combined serial source), 10 converter done, 11 break. Slot s has vector 16'hFFFE − 2·s, so the last vector is 16'hFFE8. Register 0 (pending) and register 1 (enable) hold slot s in bit s.
- R3: An event sets the pending bit of its slot whether or not that slot is enabled.
- R4: A pending maskable slot is accepted only while the mask flag (register 3, bit 0) is 0 and the slot's enable bit is 1.
- R5: When several slots are allowed through at once, the lowest slot number is accepted. The others stay pending.
- R6: Slots 0 and 11 are accepted regardless of the mask flag and the enable bits.
- R7: Polarity register 2 holds bit 0 for ext0, bit 1 for ext1 and bit 2 for both counter pins. A value of 1 selects the rising edge and 0 selects the falling edge. The opposite edge sets nothing. The key wake-up pin always acts on its falling edge.
- R8: One qualifying pin edge sets its pending bit exactly once. A level that stays put does not set it again after the bit is cleared.
- R9: An acknowledge while `irq_req` is high drops `irq_req` on the next edge, clears the accepted slot's pending bit and sets the mask flag to 1.
- R10: A write to register 0 clears every pending bit written as 0. Bits written as 1 are left unchanged.
- R11: While `irq_req` is high and no acknowledge arrives, `irq_req` and `irq_vec` hold their values.
- R12: With SPLIT_SERIAL=1, a serial receive event pends slot 8 and a transmit event pends slot 9. With SPLIT_SERIAL=0, either event pends slot 9, and slot 8 never pends and its enable bit reads 0.
- R13: An event that arrives in the same cycle as a software clear or an acknowledge of its slot leaves the slot pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_ext0 | input | 1 | External interrupt pin 0 |
| pin_ext1 | input | 1 | External interrupt pin 1 |
| pin_key | input | 1 | Key wake-up pin, shares slot 2 |
| pin_cnt0 | input | 1 | Counter pin 0, shares slot 3 |
| pin_cnt1 | input | 1 | Counter pin 1, shares slot 3 |
| ev_tmr | input | 4 | Timer event pulses, bit n is timer n |
| ev_ser_rx | input | 1 | Serial receive event pulse |
| ev_ser_tx | input | 1 | Serial transmit event pulse |
| ev_adc | input | 1 | Converter done event pulse |
| ev_brk | input | 1 | Break instruction event pulse |
| reg_addr | input | 2 | Register select: 0 pending, 1 enable, 2 polarity, 3 mask flag |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, zero-extended |
| irq_ack | input | 1 | CPU acknowledges the presented request |
| irq_req | output | 1 | Request to the CPU |
| irq_vec | output | 16 | Vector address of the accepted slot |

## Verification
The hardest situation to reach is a backlog of several sources queued behind the mask flag and then drained one acknowledge at a time. The pending order must follow slot number, and every acknowledge re-masks. The bench fires three events in a single cycle while the flag is set. It then releases the flag once per drain step and checks each vector in turn, together with what is still pending. Pin-edge cases are driven separately. The bench holds a level after software has cleared its bit and applies the opposite edge, and it confirms through the pending register that neither sets the bit again.

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter bit          SPLIT_SERIAL = 1'b1,
  parameter logic [15:0] TOP_VEC      = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pin_ext0,
  input  logic        pin_ext1,
  input  logic        pin_key,
  input  logic        pin_cnt0,
  input  logic        pin_cnt1,
  input  logic [3:0]  ev_tmr,
  input  logic        ev_ser_rx,
  input  logic        ev_ser_tx,
  input  logic        ev_adc,
  input  logic        ev_brk,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        irq_ack,
  output logic        irq_req,
  output logic [15:0] irq_vec
);
  localparam int NSLOT = 12;
  localparam int SW    = $clog2(NSLOT);
  localparam logic [NSLOT-1:0] NMI  = 12'b1000_0000_0001;
  localparam logic [NSLOT-1:0] IMPL = SPLIT_SERIAL ? 12'hFFF : 12'hEFF;
  localparam logic [NSLOT-1:0] ENM  = IMPL & ~NMI;

  logic [4:0] s1, s2, s3;
  logic [1:0] warm;
  logic [4:0] rise, fall;
  logic [NSLOT-1:0] pend_q, en_q, evt, pass, pend_n;
  logic [2:0] pol_q;
  logic dis_q, irq_q, found, take;
  logic [SW-1:0] win, sel_q;
  logic [15:0] vec_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0; warm <= '0;
    end else begin
      s1 <= {pin_cnt1, pin_cnt0, pin_key, pin_ext1, pin_ext0};
      s2 <= s1;
      s3 <= s2;
      if (warm != 2'd3) warm <= warm + 2'd1;
    end

  assign rise = (warm == 2'd3) ? (s2 & ~s3) : '0;
  assign fall = (warm == 2'd3) ? (~s2 & s3) : '0;

  always_comb begin
    evt     = '0;
    evt[1]  = pol_q[0] ? rise[0] : fall[0];
    evt[2]  = (pol_q[1] ? rise[1] : fall[1]) | fall[2];
    evt[3]  = pol_q[2] ? (rise[3] | rise[4]) : (fall[3] | fall[4]);
    evt[7:4] = ev_tmr;
    if (SPLIT_SERIAL) begin
      evt[8] = ev_ser_rx;
      evt[9] = ev_ser_tx;
    end else begin
      evt[9] = ev_ser_rx | ev_ser_tx;
    end
    evt[10] = ev_adc;
    evt[11] = ev_brk;
  end

  assign pass = pend_q & (NMI | (en_q & {NSLOT{~dis_q}}));

  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (pass[i]) begin
        found = 1'b1;
        win   = SW'(i);
      end
  end

  assign take = irq_q & irq_ack;

  always_comb begin
    pend_n = pend_q;
    if (reg_wr && reg_addr == 2'd0) pend_n = pend_n & reg_wdata[NSLOT-1:0];
    if (take) pend_n[sel_q] = 1'b0;
    pend_n = (pend_n | evt) & IMPL;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_q <= 12'h001;
      en_q   <= '0;
      pol_q  <= '0;
      dis_q  <= 1'b1;
    end else begin
      pend_q <= pend_n;
      if (reg_wr && reg_addr == 2'd1) en_q  <= reg_wdata[NSLOT-1:0] & ENM;
      if (reg_wr && reg_addr == 2'd2) pol_q <= reg_wdata[2:0];
      if (take)                       dis_q <= 1'b1;
      else if (reg_wr && reg_addr == 2'd3) dis_q <= reg_wdata[0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_q <= 1'b0;
      sel_q <= '0;
      vec_q <= TOP_VEC;
    end else if (irq_q) begin
      if (irq_ack) irq_q <= 1'b0;
    end else if (found) begin
      irq_q <= 1'b1;
      sel_q <= win;
      vec_q <= TOP_VEC - {11'd0, win, 1'b0};
    end

  assign irq_req = irq_q;
  assign irq_vec = vec_q;

  always_comb
    case (reg_addr)
      2'd0:    reg_rdata = {4'd0, pend_q};
      2'd1:    reg_rdata = {4'd0, en_q};
      2'd2:    reg_rdata = {13'd0, pol_q};
      default: reg_rdata = {15'd0, dis_q};
    endcase
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq_req,
  input logic        irq_ack,
  input logic [15:0] irq_vec,
  input logic        dis_q,
  input logic [11:0] en_q
);
  logic [11:0] en_d;
  logic        dis_d;
  logic [15:0] off;
  logic [3:0]  slot;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_d  <= '0;
      dis_d <= 1'b1;
    end else begin
      en_d  <= en_q;
      dis_d <= dis_q;
    end

  assign off  = 16'hFFFE - irq_vec;
  assign slot = off[4:1];

  p_vec_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec[0] == 1'b0 && irq_vec >= 16'hFFE8));

  p_vec_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec)));

  p_ack_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack) |=> !irq_req);

  p_ack_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack) |=> dis_q);

  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_req) && slot != 4'd0 && slot != 4'd11) |-> (!dis_d && en_d[slot]));
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
  .irq_vec(irq_vec), .dis_q(dis_q), .en_q(en_q)
);

// File: tb/vec_irq_ctrl_bench.sv
`timescale 1ns/1ps
module vec_irq_ctrl_bench;
  logic clk = 0, rst_n = 0;
  logic pin_ext0 = 0, pin_ext1 = 0, pin_key = 0, pin_cnt0 = 0, pin_cnt1 = 0;
  logic [3:0] ev_tmr = 0;
  logic ev_ser_rx = 0, ev_ser_tx = 0, ev_adc = 0, ev_brk = 0;
  logic [1:0] reg_addr = 0;
  logic reg_wr = 0;
  logic [15:0] reg_wdata = 0;
  logic irq_ack = 0;
  logic [15:0] rdata, rdata_b, vec, vec_b;
  logic req, req_b;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  vec_irq_ctrl #(.SPLIT_SERIAL(1'b1)) u_vec_irq_ctrl (
    .clk, .rst_n, .pin_ext0, .pin_ext1, .pin_key, .pin_cnt0, .pin_cnt1,
    .ev_tmr, .ev_ser_rx, .ev_ser_tx, .ev_adc, .ev_brk,
    .reg_addr, .reg_wr, .reg_wdata, .reg_rdata(rdata),
    .irq_ack, .irq_req(req), .irq_vec(vec));

  vec_irq_ctrl #(.SPLIT_SERIAL(1'b0)) u_vec_irq_ctrl_base (
    .clk, .rst_n, .pin_ext0, .pin_ext1, .pin_key, .pin_cnt0, .pin_cnt1,
    .ev_tmr, .ev_ser_rx, .ev_ser_tx, .ev_adc, .ev_brk,
    .reg_addr, .reg_wr, .reg_wdata, .reg_rdata(rdata_b),
    .irq_ack, .irq_req(req_b), .irq_vec(vec_b));

  task automatic check(string req_tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req_tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    tick(1);
    reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d, output logic [15:0] db);
    reg_addr = a; #1; d = rdata; db = rdata_b;
  endtask

  task automatic ack();
    irq_ack = 1; tick(1); irq_ack = 0;
  endtask

  task automatic t_reset();
    logic [15:0] d, db;
    rd(0, d, db); check("R1 pend", d, 16'h0001);
    rd(1, d, db); check("R1 en", d, 16'h0000);
    rd(2, d, db); check("R1 pol", d, 16'h0000);
    rd(3, d, db); check("R1 mask", d, 16'h0001);
    tick(1);
    check("R1 R6 req", {15'd0, req}, 16'd1);
    check("R1 vec", vec, 16'hFFFE);
    tick(3);
    check("R11 vec hold", vec, 16'hFFFE);
    ack();
    check("R9 req drop", {15'd0, req}, 16'd0);
    rd(0, d, db); check("R9 pend clr", d, 16'h0000);
  endtask

  task automatic t_mask();
    logic [15:0] d, db;
    ev_tmr = 4'b0001; tick(1); ev_tmr = 0; tick(2);
    check("R3 no req", {15'd0, req}, 16'd0);
    rd(0, d, db); check("R3 pend", d, 16'h0010);
    wr(1, 16'h0010); tick(2);
    check("R4 masked by flag", {15'd0, req}, 16'd0);
    wr(3, 16'h0000); tick(2);
    check("R4 req", {15'd0, req}, 16'd1);
    check("R2 vec t0", vec, 16'hFFF6);
    tick(4);
    check("R11 stable", vec, 16'hFFF6);
    ack();
    rd(3, d, db); check("R9 mask set", d, 16'h0001);
    rd(0, d, db); check("R9 pend t0 clr", d, 16'h0000);
  endtask

  task automatic t_prio();
    logic [15:0] d, db;
    wr(1, 16'h04F0);
    ev_tmr = 4'b1010; ev_adc = 1; tick(1); ev_tmr = 0; ev_adc = 0;
    wr(3, 0); tick(2);
    check("R5 first", vec, 16'hFFF4);
    rd(0, d, db); check("R5 others wait", d, 16'h04A0);
    ack();
    wr(3, 0); tick(2);
    check("R5 second", vec, 16'hFFF0);
    ack();
    wr(3, 0); tick(2);
    check("R5 third", vec, 16'hFFEA);
    ack();
    rd(0, d, db); check("R5 drained", d, 16'h0000);
    wr(1, 16'h0000);
  endtask

  task automatic t_brk();
    ev_brk = 1; tick(1); ev_brk = 0; tick(2);
    check("R6 brk req", {15'd0, req}, 16'd1);
    check("R6 R2 brk vec", vec, 16'hFFE8);
    ack();
  endtask

  task automatic t_pins();
    logic [15:0] d, db;
    wr(2, 16'h0001);
    pin_ext0 = 1; tick(6);
    rd(0, d, db); check("R7 rise ext0", d, 16'h0002);
    wr(0, 16'h0000); tick(6);
    rd(0, d, db); check("R8 held level", d, 16'h0000);
    pin_ext0 = 0; tick(6);
    rd(0, d, db); check("R7 wrong edge", d, 16'h0000);
    wr(2, 16'h0000);
    pin_ext0 = 1; tick(6);
    rd(0, d, db); check("R7 rise ignored", d, 16'h0000);
    pin_ext0 = 0; tick(6);
    rd(0, d, db); check("R7 fall ext0", d, 16'h0002);
    wr(0, 0);
    pin_key = 1; tick(6);
    rd(0, d, db); check("R7 key rise", d, 16'h0000);
    pin_key = 0; tick(6);
    rd(0, d, db); check("R7 key fall", d, 16'h0004);
    wr(0, 0);
    wr(2, 16'h0004);
    pin_cnt1 = 1; tick(6);
    rd(0, d, db); check("R7 cnt1 rise", d, 16'h0008);
    wr(0, 16'hFFFF); tick(1);
    rd(0, d, db); check("R10 ones keep", d, 16'h0008);
    wr(0, 16'hFFF7); tick(1);
    rd(0, d, db); check("R10 zero clears", d, 16'h0000);
    pin_cnt1 = 0; wr(2, 0); tick(6);
  endtask

  task automatic t_collide();
    logic [15:0] d, db;
    ev_tmr = 4'b0001; reg_addr = 0; reg_wdata = 0; reg_wr = 1;
    tick(1);
    ev_tmr = 0; reg_wr = 0;
    rd(0, d, db); check("R13 event wins", d, 16'h0010);
    wr(0, 0);
  endtask

  task automatic t_split();
    logic [15:0] d, db;
    ev_ser_rx = 1; ev_ser_tx = 1; tick(1); ev_ser_rx = 0; ev_ser_tx = 0;
    rd(0, d, db);
    check("R12 split pend", d, 16'h0300);
    check("R12 base pend", db, 16'h0200);
    wr(1, 16'h0300);
    rd(1, d, db); check("R12 base en", db, 16'h0200);
    wr(3, 0); tick(2);
    check("R12 split vec", vec, 16'hFFEE);
    check("R12 base vec", vec_b, 16'hFFEC);
    ack();
    rd(0, d, db);
    check("R12 split left", d, 16'h0200);
    check("R12 base left", db, 16'h0000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    t_reset();
    tick(4);
    t_mask();
    t_prio();
    t_brk();
    t_pins();
    t_collide();
    t_split();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule